// File: doc/BRIEF.md
# Event-Driven Leaky Integrate-and-Fire Unit

This block holds the membrane state of a small population of leaky integrate-and-fire neurons and touches a neuron only when a weighted input event for it arrives. Each event carries a neuron index, a signed Q1.15 weight and the arrival time. The arrival time is split into a millisecond count and a 0–999 microsecond field. On an event the unit works out how long the neuron has been idle from the stamped times, so queueing delay before the block has no effect. It decays the stored potential by that span, adds the weight, and tests the threshold. The updated potential and the spike decision appear on the outputs one clock later.

The decay factor is the product of two precomputed tables. One table holds exp(-k/TAU) for k = 0..999 µs. The other holds the same curve at whole-millisecond steps over a configurable span. A neuron that has been idle for longer than that span has its potential cleared to zero. When a neuron fires, its potential is loaded with a programmable reset level. One event can be accepted on every clock.

Top module: `lif_event_unit`

## Requirements
- R1: Synchronous active-high reset clears every neuron's potential to 0 and its last-update time to 0 ms / 0 µs, and holds out_valid and out_spike low.
- R2: out_valid is high in exactly the cycle after a cycle with ev_valid high, and out_neuron then carries that event's index. Without an event, no output is produced and no neuron state changes.
- R3: The elapsed time is measured from the event's own timestamp (ev_ms, ev_us), not from the cycle of arrival. It is split as follows: if ev_us >= last_us, the µs gap is ev_us-last_us and the ms gap is ev_ms-last_ms. Otherwise the µs gap is ev_us+1000-last_us and the ms gap is ev_ms-last_ms-1. The ms subtraction wraps modulo 2^MS_W.
- R4: The table entries are E(s) = round(32768*exp(-s/TAU_US)), with 32768 meaning 1.0. The µs table holds E(u), and the ms table holds E(1000*m) for m < MS_SPAN. The decay factor is (Eus*Ems + 16384) >> 15.
- R5: The decayed potential is (v*factor + 16384) >>> 15, where v is the stored signed Q1.15 potential.
- R6: When the ms gap is MS_SPAN or more, the decayed potential is 0.
- R7: The weight is added to the decayed potential and the sum saturates to [-32768, 32767].
- R8: out_spike is 1 when the saturated sum is greater than or equal to v_thresh (signed). It is reported in the same output cycle as the update.
- R9: A neuron that spikes stores v_reset and a neuron that does not spike stores the saturated sum. In both cases the event's timestamp becomes the last-update time, and out_potential shows the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Input event present this cycle |
| ev_neuron | input | IDX_W | Target neuron index |
| ev_weight | input | 16 | Signed Q1.15 synaptic weight |
| ev_ms | input | MS_W | Arrival time, whole milliseconds |
| ev_us | input | 10 | Arrival time, microseconds within the millisecond (0–999) |
| v_thresh | input | 16 | Signed firing threshold |
| v_reset | input | 16 | Signed potential loaded after a spike |
| out_valid | output | 1 | Update result valid |
| out_neuron | output | IDX_W | Neuron that was updated |
| out_potential | output | 16 | Stored potential after the update |
| out_spike | output | 1 | Neuron fired on this event |

## Verification
Every event produces its own result one cycle later, so a wrong stored potential or timestamp shows up on out_potential at the next event for the same neuron. The bench returns to neurons several times, with gaps that cross millisecond borrows and exceed the table span, so that stale state becomes visible. State that survives reset is exposed by an event that reuses a neuron's last timestamp: with zero elapsed time, any leftover potential passes through undecayed. The bench also checks threshold equality, saturation at both ends and a changed reset level one cycle after each event.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int FX_W      = 16;
  localparam int FAC_W     = 17;
  localparam int US_PER_MS = 1000;
  localparam int US_W      = 10;

  typedef logic signed [FX_W-1:0] fx_t;
  typedef logic [FAC_W-1:0]       fac_t;

  // exp(-steps/tau) in Q1.15, 32768 meaning 1.0, rounded to nearest
  function automatic fac_t decay_entry(input int steps_us, input int tau_us);
    real x;
    x = 32768.0 * $exp(-real'(steps_us) / real'(tau_us));
    return fac_t'($rtoi(x + 0.5));
  endfunction

  function automatic fx_t sat_fx(input logic signed [FX_W:0] v);
    if (v > 17'sd32767)       return 16'sh7FFF;
    else if (v < -17'sd32768) return 16'sh8000;
    else                      return v[FX_W-1:0];
  endfunction
endpackage

// File: rtl/lif_decay_table.sv
module lif_decay_table
  import lif_pkg::*;
#(
  parameter int MS_SPAN = 64,
  parameter int TAU_US  = 20000,
  parameter int MS_W    = 16
) (
  input  logic [MS_W-1:0] ms_gap,
  input  logic [US_W-1:0] us_gap,
  output fac_t            factor
);
  localparam int MSI_W  = (MS_SPAN > 1) ? $clog2(MS_SPAN) : 1;
  localparam int US_N   = 1 << US_W;
  localparam int MS_N   = 1 << MSI_W;

  fac_t us_rom [US_N];
  fac_t ms_rom [MS_N];

  initial begin
    for (int k = 0; k < US_N; k++) us_rom[k] = decay_entry(k, TAU_US);
    for (int m = 0; m < MS_N; m++) ms_rom[m] = decay_entry(m * US_PER_MS, TAU_US);
  end

  logic                 in_span;
  logic [2*FAC_W-1:0]   prod;
  logic [2*FAC_W-1:0]   rounded;

  always_comb begin
    in_span = (ms_gap < MS_W'(MS_SPAN));
    prod    = us_rom[us_gap] * ms_rom[ms_gap[MSI_W-1:0]];
    rounded = (prod + (2*FAC_W)'(16384)) >> 15;
    factor  = in_span ? rounded[FAC_W-1:0] : '0;
  end
endmodule

// File: rtl/lif_fx_scale.sv
module lif_fx_scale
  import lif_pkg::*;
(
  input  fx_t  v_in,
  input  fac_t factor,
  output fx_t  v_out
);
  logic signed [2*FAC_W-1:0] prod;
  logic signed [2*FAC_W-1:0] rounded;

  always_comb begin
    prod    = v_in * $signed({1'b0, factor});
    rounded = (prod + 34'sd16384) >>> 15;
    v_out   = rounded[FX_W-1:0];
  end
endmodule

// File: rtl/lif_event_unit.sv
module lif_event_unit
  import lif_pkg::*;
#(
  parameter int N_NEURONS = 16,
  parameter int MS_SPAN   = 64,
  parameter int TAU_US    = 20000,
  parameter int MS_W      = 16,
  localparam int IDX_W    = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ev_valid,
  input  logic [IDX_W-1:0]        ev_neuron,
  input  logic signed [FX_W-1:0]  ev_weight,
  input  logic [MS_W-1:0]         ev_ms,
  input  logic [US_W-1:0]         ev_us,
  input  logic signed [FX_W-1:0]  v_thresh,
  input  logic signed [FX_W-1:0]  v_reset,
  output logic                    out_valid,
  output logic [IDX_W-1:0]        out_neuron,
  output logic signed [FX_W-1:0]  out_potential,
  output logic                    out_spike
);
  // per-neuron state, distributed RAM with asynchronous read
  fx_t             pot_mem [N_NEURONS];
  logic [MS_W-1:0] lms_mem [N_NEURONS];
  logic [US_W-1:0] lus_mem [N_NEURONS];

  fx_t                 cur_v;
  logic [MS_W-1:0]     last_ms;
  logic [US_W-1:0]     last_us;
  logic                borrow;
  logic [US_W-1:0]     us_gap;
  logic [MS_W-1:0]     ms_gap;
  fac_t                factor;
  fx_t                 decayed;
  logic signed [FX_W:0] sum_wide;
  fx_t                 sum_sat;
  logic                fire;
  fx_t                 next_v;

  always_comb begin
    cur_v   = pot_mem[ev_neuron];
    last_ms = lms_mem[ev_neuron];
    last_us = lus_mem[ev_neuron];
    borrow  = (ev_us < last_us);
    us_gap  = ev_us + (borrow ? US_W'(US_PER_MS) : '0) - last_us;
    ms_gap  = ev_ms - last_ms - MS_W'(borrow);
  end

  lif_decay_table #(
    .MS_SPAN (MS_SPAN),
    .TAU_US  (TAU_US),
    .MS_W    (MS_W)
  ) u_table (
    .ms_gap  (ms_gap),
    .us_gap  (us_gap),
    .factor  (factor)
  );

  lif_fx_scale u_scale (
    .v_in    (cur_v),
    .factor  (factor),
    .v_out   (decayed)
  );

  always_comb begin
    sum_wide = {decayed[FX_W-1], decayed} + {ev_weight[FX_W-1], ev_weight};
    sum_sat  = sat_fx(sum_wide);
    fire     = (sum_sat >= v_thresh);
    next_v   = fire ? v_reset : sum_sat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_spike     <= 1'b0;
      out_neuron    <= '0;
      out_potential <= '0;
      for (int i = 0; i < N_NEURONS; i++) begin
        pot_mem[i] <= '0;
        lms_mem[i] <= '0;
        lus_mem[i] <= '0;
      end
    end else begin
      out_valid <= ev_valid;
      out_spike <= ev_valid & fire;
      if (ev_valid) begin
        out_neuron         <= ev_neuron;
        out_potential      <= next_v;
        pot_mem[ev_neuron] <= next_v;
        lms_mem[ev_neuron] <= ev_ms;
        lus_mem[ev_neuron] <= ev_us;
      end
    end
  end
endmodule

// File: rtl/lif_event_unit_chk.sv
module lif_event_unit_chk #(
  parameter int IDX_W = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ev_valid,
  input logic [IDX_W-1:0]        ev_neuron,
  input logic signed [15:0]      v_thresh,
  input logic signed [15:0]      v_reset,
  input logic                    out_valid,
  input logic [IDX_W-1:0]        out_neuron,
  input logic signed [15:0]      out_potential,
  input logic                    out_spike
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_spike));

  a_r2_event_gives_result: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> (out_valid && out_neuron == $past(ev_neuron)));

  a_r2_no_event_no_result: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> !out_valid);

  a_r8_spike_needs_result: assert property (@(posedge clk) disable iff (rst)
    out_spike |-> out_valid);

  a_r9_spike_loads_reset: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> (!out_spike || out_potential == $past(v_reset)));

  a_r8_quiet_below_threshold: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> (out_spike || out_potential < $past(v_thresh)));
endmodule

bind lif_event_unit lif_event_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ev_valid      (ev_valid),
  .ev_neuron     (ev_neuron),
  .v_thresh      (v_thresh),
  .v_reset       (v_reset),
  .out_valid     (out_valid),
  .out_neuron    (out_neuron),
  .out_potential (out_potential),
  .out_spike     (out_spike)
);

// File: tb/lif_event_unit_tb.sv
module lif_event_unit_tb;
  localparam int N       = 16;
  localparam int MS_SPAN = 64;
  localparam int TAU     = 20000;
  localparam int MS_W    = 16;
  localparam int IDX_W   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_valid = 1'b0;
  logic [IDX_W-1:0] ev_neuron = '0;
  logic signed [15:0] ev_weight = '0;
  logic [MS_W-1:0] ev_ms = '0;
  logic [9:0] ev_us = '0;
  logic signed [15:0] v_thresh = 16'sd10000;
  logic signed [15:0] v_reset = -16'sd2000;
  logic out_valid;
  logic [IDX_W-1:0] out_neuron;
  logic signed [15:0] out_potential;
  logic out_spike;

  always #5 clk = ~clk;

  lif_event_unit #(.N_NEURONS(N), .MS_SPAN(MS_SPAN), .TAU_US(TAU), .MS_W(MS_W)) u_dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_neuron(ev_neuron),
    .ev_weight(ev_weight), .ev_ms(ev_ms), .ev_us(ev_us),
    .v_thresh(v_thresh), .v_reset(v_reset), .out_valid(out_valid),
    .out_neuron(out_neuron), .out_potential(out_potential), .out_spike(out_spike)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int m_pot [N];
  int m_ms [N];
  int m_us [N];

  // neuron, weight, ms, us, expected spike
  localparam int VEC [12][5] = '{
    '{0,   3000,   1,   0, 0},
    '{0,   3000,   1, 500, 0},
    '{0,   5000,   2,   0, 1},
    '{1,  -4000,   3,   0, 0},
    '{1,   2000,   3, 999, 0},
    '{0,   1000,   5,   0, 0},
    '{2,  32000,  10,   0, 1},
    '{3, -30000,  10,   0, 0},
    '{3, -30000,  10,   0, 0},
    '{1,    500, 100,   0, 0},
    '{4,   8000,  20, 700, 0},
    '{4,   1000,  21, 300, 0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ent(input int s);
    return $rtoi(32768.0 * $exp(-real'(s) / real'(TAU)) + 0.5);
  endfunction

  // R3..R9 reference arithmetic
  task automatic model(input int n, input int w, input int ms, input int us,
                       output int pot, output bit spk);
    int b, ug, mg, f, vd, s;
    longint p;
    b  = (us < m_us[n]) ? 1 : 0;
    ug = us + (b == 1 ? 1000 : 0) - m_us[n];
    mg = (ms - m_ms[n] - b) & 32'h0000FFFF;
    if (mg >= MS_SPAN) f = 0;
    else f = int'((longint'(ent(ug)) * longint'(ent(mg * 1000)) + 16384) >>> 15);
    p  = longint'(m_pot[n]) * f + 16384;
    vd = int'(p >>> 15);
    s  = vd + w;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    spk = (s >= int'(v_thresh));
    pot = spk ? int'(v_reset) : s;
    m_pot[n] = pot;
    m_ms[n]  = ms;
    m_us[n]  = us;
  endtask

  task automatic send(input int n, input int w, input int ms, input int us,
                      output int act_pot, output bit act_spk, output int exp_pot, output bit exp_spk);
    model(n, w, ms, us, exp_pot, exp_spk);
    ev_neuron = IDX_W'(n);
    ev_weight = 16'(w);
    ev_ms     = MS_W'(ms);
    ev_us     = 10'(us);
    ev_valid  = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
    check(out_valid == 1'b1 && int'(out_neuron) == n, "R2 result valid/neuron",
          int'(out_neuron), n);
    act_pot = int'(out_potential);
    act_spk = out_spike;
  endtask

  task automatic clear_model();
    for (int i = 0; i < N; i++) begin
      m_pot[i] = 0; m_ms[i] = 0; m_us[i] = 0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R2 watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int ap, ep;
    bit as, es;
    bit quiet;
    clear_model();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_spike == 1'b0, "R1 outputs low in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R2 no result without event", int'(out_valid), 0);

    // vector walk: R3 borrow, R4/R5 decay, R6 span, R7 saturation, R8 spike
    for (int i = 0; i < 12; i++) begin
      send(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], ap, as, ep, es);
      check(ap == ep, $sformatf("R5 potential vec%0d", i), ap, ep);
      check(as == bit'(VEC[i][4]) && as == es, $sformatf("R8 spike vec%0d", i),
            int'(as), VEC[i][4]);
    end
    // R7: negative saturation exactly at the rail
    check(m_pot[3] == -32768, "R7 negative saturation", m_pot[3], -32768);
    // R6: neuron 1 idle beyond span -> only weight remains
    check(m_pot[1] == 500, "R6 span exceeded clears potential", m_pot[1], 500);

    // R8: equality with threshold fires, one below does not
    send(6, 10000, 40, 0, ap, as, ep, es);
    check(as == 1'b1, "R8 spike at threshold", int'(as), 1);
    check(ap == -2000, "R9 reset level after spike", ap, -2000);
    send(7, 9999, 40, 0, ap, as, ep, es);
    check(as == 1'b0 && ap == 9999, "R8 no spike below threshold", ap, 9999);

    // R9: programmable reset level
    v_reset = 16'sd123;
    send(6, 20000, 40, 0, ap, as, ep, es);
    check(as == 1'b1 && ap == 123, "R9 new reset level", ap, 123);

    // R3: long idle gap in cycles does not matter, only timestamps
    send(8, 4000, 30, 0, ap, as, ep, es);
    quiet = 1'b1;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (out_valid) quiet = 1'b0;
    end
    check(quiet, "R2 no output while idle", int'(!quiet), 0);
    send(8, 0, 31, 0, ap, as, ep, es);
    check(ap == ep && ap < 4000 && ap > 3000, "R3 timestamp decay after idle", ap, ep);

    // R1: reset clears state; same timestamp would otherwise pass -32768 through
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 quiet after reset", int'(out_valid), 0);
    rst = 1'b0;
    clear_model();
    v_reset = -16'sd2000;
    send(3, 100, 10, 0, ap, as, ep, es);
    check(ap == ep && ap == 100, "R1 state cleared by reset", ap, 100);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule